// File: doc/BRIEF.md
# Pad Connectivity AND-Tree Tester

This block sits between a chip's pads and its core logic and provides a manufacturing test for board-level connectivity. While an active-low test-enable input is held low, the input value of every participating pad is combined in a single AND tree. The result is driven onto one shared pin. In normal operation, that shared pin carries a memory-access-control signal from the core. A tester holds all pads high through the enabled pull-ups and then pulls one pad low at a time. If the shared pin does not follow the pad low, that pad is not properly attached.

In test mode, the block also turns off every output driver it controls and enables pull-ups on the participating pads, so that no pad fights the tester. A parameter mask chooses which pads take part in the tree. A group of high-speed bus pads is normally left out, and those pads can toggle freely without disturbing the result. The whole test path is combinational from the pads, so the test works with no clock running.

Top module: `conn_and_tree_tester`

## Requirements
- R1: Test mode is active when `test_en_n` is 0 and inactive when it is 1. No clock edge is needed to enter or leave test mode.
- R2: In test mode, `shared_oe_o` is 1. `shared_out_o` equals the AND of `pad_in_i[i]` over every pad i whose bit in `PART_MASK` is 1, and it updates with no clock edge.
- R3: In test mode, pads whose `PART_MASK` bit is 0 have no effect on `shared_out_o`, whatever their value.
- R4: In test mode, with all other participating pads high, driving any single participating pad low makes `shared_out_o` 0.
- R5: In test mode, every bit of `pad_oe_o` is 0, whatever `core_oe_i` holds.
- R6: In test mode, `pad_pu_en_o` equals `PART_MASK`. Outside test mode, `pad_pu_en_o` is all zeros.
- R7: Outside test mode, `shared_out_o` equals `shared_func_i` and `shared_oe_o` equals `shared_func_oe_i`. The tree result does not appear on the shared pin.
- R8: Outside test mode, `pad_oe_o` equals `core_oe_i`. `pad_out_o` equals `core_out_i` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_en_n | input | 1 | Active-low connectivity test enable |
| pad_in_i | input | NUM_PADS | Values received from the pads |
| core_out_i | input | NUM_PADS | Output values from the core |
| core_oe_i | input | NUM_PADS | Output enables from the core, 1 = drive |
| pad_out_o | output | NUM_PADS | Output values to the pad drivers |
| pad_oe_o | output | NUM_PADS | Output enables to the pad drivers, 1 = drive |
| pad_pu_en_o | output | NUM_PADS | Pull-up enables per pad, 1 = enabled |
| shared_func_i | input | 1 | Normal memory-access-control value for the shared pin |
| shared_func_oe_i | input | 1 | Normal output enable for the shared pin |
| shared_out_o | output | 1 | Value driven on the shared pin |
| shared_oe_o | output | 1 | Output enable of the shared pin |

## Verification
The hardest case to reach from the ports is a fault on a single pad that is hidden by other pads. A stuck or broken leaf only shows when every other participating pad is high, and excluded pads must be shown to have no effect even while they are low. The bench therefore sweeps all input values of the sixteen pads in test mode and compares each one against an AND computed in the bench. It also walks a single zero across every pad and toggles the excluded group on its own. Between the sweeps, the bench switches the mode without any clock edge to show that the path is combinational.

// File: rtl/conn_tree_pkg.sv
package conn_tree_pkg;

  // Number of tree levels needed to reduce n leaves to one root.
  function automatic int tree_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return l;
  endfunction

  // Operating mode of the pad ring.
  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_CONN = 1'b1
  } pad_mode_e;

endpackage

// File: rtl/ctt_and_tree.sv
module ctt_and_tree #(
  parameter int NUM_LEAVES = 16
) (
  input  logic [NUM_LEAVES-1:0] leaves_i,
  output logic                  root_o
);
  import conn_tree_pkg::*;

  localparam int LVLS   = (NUM_LEAVES < 2) ? 1 : tree_levels(NUM_LEAVES);
  localparam int LEAVES = 1 << LVLS;

  logic [LEAVES-1:0] padded;

  always_comb begin
    padded = '1;
    padded[NUM_LEAVES-1:0] = leaves_i;
  end

  for (genvar l = 0; l <= LVLS; l++) begin : lvl_g
    localparam int W = LEAVES >> l;
    logic [W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = padded;
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_pair
        assign v[k] = lvl_g[l-1].v[2*k] & lvl_g[l-1].v[2*k+1];
      end
    end
  end

  assign root_o = lvl_g[LVLS].v[0];

  // Any low leaf must reach the root; all-high leaves must give a high root.
  always_comb begin
    if (leaves_i != '1) begin
      a_r4_low_reaches_root: assert (root_o == 1'b0)
        else $error("low leaf did not reach root");
    end else begin
      a_r2_all_high_root: assert (root_o == 1'b1)
        else $error("root low with all leaves high");
    end
  end

endmodule

// File: rtl/ctt_pad_ctrl.sv
module ctt_pad_ctrl #(
  parameter int              NUM_PADS  = 16,
  parameter logic [NUM_PADS-1:0] PART_MASK = '1
) (
  input  conn_tree_pkg::pad_mode_e mode_i,
  input  logic [NUM_PADS-1:0]      pad_in_i,
  input  logic [NUM_PADS-1:0]      core_out_i,
  input  logic [NUM_PADS-1:0]      core_oe_i,
  output logic [NUM_PADS-1:0]      pad_out_o,
  output logic [NUM_PADS-1:0]      pad_oe_o,
  output logic [NUM_PADS-1:0]      pad_pu_en_o,
  output logic [NUM_PADS-1:0]      leaf_o
);
  import conn_tree_pkg::*;

  logic conn;
  assign conn = (mode_i == MODE_CONN);

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    assign pad_out_o[i] = core_out_i[i];
    assign pad_oe_o[i]  = core_oe_i[i] & ~conn;
    if (PART_MASK[i]) begin : g_part
      assign pad_pu_en_o[i] = conn;
      assign leaf_o[i]      = pad_in_i[i];
    end else begin : g_excl
      assign pad_pu_en_o[i] = 1'b0;
      assign leaf_o[i]      = 1'b1;
    end
  end

  always_comb begin
    if (conn) begin
      a_r5_drivers_off: assert (pad_oe_o == '0)
        else $error("driver enabled in connectivity mode");
    end
  end

endmodule

// File: rtl/ctt_shared_mux.sv
module ctt_shared_mux (
  input  conn_tree_pkg::pad_mode_e mode_i,
  input  logic                     tree_i,
  input  logic                     func_i,
  input  logic                     func_oe_i,
  output logic                     out_o,
  output logic                     oe_o
);
  import conn_tree_pkg::*;

  always_comb begin
    unique case (mode_i)
      MODE_CONN: begin
        out_o = tree_i;
        oe_o  = 1'b1;
      end
      default: begin
        out_o = func_i;
        oe_o  = func_oe_i;
      end
    endcase
  end

endmodule

// File: rtl/conn_and_tree_tester.sv
module conn_and_tree_tester #(
  parameter int                  NUM_PADS  = 16,
  parameter logic [NUM_PADS-1:0] PART_MASK = 16'hF0FF
) (
  input  logic                test_en_n,
  input  logic [NUM_PADS-1:0] pad_in_i,
  input  logic [NUM_PADS-1:0] core_out_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic [NUM_PADS-1:0] pad_pu_en_o,
  input  logic                shared_func_i,
  input  logic                shared_func_oe_i,
  output logic                shared_out_o,
  output logic                shared_oe_o
);
  import conn_tree_pkg::*;

  pad_mode_e           mode;
  logic [NUM_PADS-1:0] leaves;
  logic                tree_root;

  assign mode = test_en_n ? MODE_FUNC : MODE_CONN;

  ctt_pad_ctrl #(
    .NUM_PADS  (NUM_PADS),
    .PART_MASK (PART_MASK)
  ) pad_ctrl_i (
    .mode_i      (mode),
    .pad_in_i    (pad_in_i),
    .core_out_i  (core_out_i),
    .core_oe_i   (core_oe_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pad_pu_en_o (pad_pu_en_o),
    .leaf_o      (leaves)
  );

  ctt_and_tree #(
    .NUM_LEAVES (NUM_PADS)
  ) tree_i (
    .leaves_i (leaves),
    .root_o   (tree_root)
  );

  ctt_shared_mux shared_mux_i (
    .mode_i    (mode),
    .tree_i    (tree_root),
    .func_i    (shared_func_i),
    .func_oe_i (shared_func_oe_i),
    .out_o     (shared_out_o),
    .oe_o      (shared_oe_o)
  );

  // Cross-module checks between port inputs and the muxed pin.
  always_comb begin
    if (!test_en_n) begin
      a_r2_pin_follows_tree: assert (shared_oe_o && (shared_out_o == tree_root))
        else $error("shared pin not carrying tree result");
      a_r6_pullups_on: assert (pad_pu_en_o == PART_MASK)
        else $error("pull-ups do not match mask");
    end else begin
      a_r7_normal_function: assert (shared_out_o == shared_func_i && shared_oe_o == shared_func_oe_i)
        else $error("shared pin not in normal function");
      a_r6_pullups_off: assert (pad_pu_en_o == '0)
        else $error("pull-ups on outside test");
      a_r8_oe_passthru: assert (pad_oe_o == core_oe_i)
        else $error("output enables altered outside test");
    end
  end

endmodule

// File: tb/conn_and_tree_tester_tb_top.sv
module conn_and_tree_tester_tb_top;
  localparam int          N    = 16;
  localparam logic [N-1:0] MASK = 16'hF0FF;

  logic          clk = 1'b0;
  logic          test_en_n;
  logic [N-1:0]  pad_in, core_out, core_oe;
  logic [N-1:0]  pad_out, pad_oe, pad_pu;
  logic          sfunc, sfunc_oe, sout, soe;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  conn_and_tree_tester #(.NUM_PADS(N), .PART_MASK(MASK)) dut_i (
    .test_en_n        (test_en_n),
    .pad_in_i         (pad_in),
    .core_out_i       (core_out),
    .core_oe_i        (core_oe),
    .pad_out_o        (pad_out),
    .pad_oe_o         (pad_oe),
    .pad_pu_en_o      (pad_pu),
    .shared_func_i    (sfunc),
    .shared_func_oe_i (sfunc_oe),
    .shared_out_o     (sout),
    .shared_oe_o      (soe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_tree(input logic [N-1:0] v);
    return &(v | ~MASK);
  endfunction

  initial begin
    test_en_n = 1'b1; pad_in = '1; core_out = 16'hA5C3; core_oe = 16'h3C96;
    sfunc = 1'b0; sfunc_oe = 1'b1;
    #3;
    // Initial normal state: R1 R7 R8 R6
    chk("R7 out", {31'd0, sout}, 32'd0);
    chk("R7 oe", {31'd0, soe}, 32'd1);
    chk("R8 oe", {16'd0, pad_oe}, {16'd0, core_oe});
    chk("R8 out", {16'd0, pad_out}, {16'd0, core_out});
    chk("R6 off", {16'd0, pad_pu}, 32'd0);
    // Normal mode: tree must not reach the pin (R7)
    pad_in = 16'h0000; sfunc = 1'b1; sfunc_oe = 1'b0; #1;
    chk("R7 tree hidden", {31'd0, sout}, 32'd1);
    chk("R7 oe follows", {31'd0, soe}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      sfunc = k[0]; sfunc_oe = k[1]; core_oe = 16'h1111 << k; #1;
      chk("R7 func", {30'd0, soe, sout}, {30'd0, k[1], k[0]});
      chk("R8 oe", {16'd0, pad_oe}, {16'd0, core_oe});
    end
    // Enter test mode between clock edges (R1)
    @(negedge clk); #2;
    pad_in = '1; core_oe = '1; test_en_n = 1'b0; #1;
    chk("R1 enter", {31'd0, sout}, 32'd1);
    chk("R2 oe", {31'd0, soe}, 32'd1);
    chk("R5 drivers off", {16'd0, pad_oe}, 32'd0);
    chk("R6 pullups", {16'd0, pad_pu}, {16'd0, MASK});
    chk("R8 out test", {16'd0, pad_out}, {16'd0, core_out});
    // Walking zero (R4, R3)
    for (int i = 0; i < N; i++) begin
      pad_in = ~(16'h1 << i); #1;
      if (MASK[i]) chk("R4 walk zero", {31'd0, sout}, 32'd0);
      else         chk("R3 excluded zero", {31'd0, sout}, 32'd1);
    end
    // Excluded group toggling alone (R3)
    for (int k = 0; k < 16; k++) begin
      pad_in = MASK | (16'(k) << 8); #1;
      chk("R3 excluded toggle", {31'd0, sout}, 32'd1);
    end
    // Exhaustive sweep (R2)
    for (int v = 0; v < (1 << N); v++) begin
      pad_in = v[N-1:0];
      core_oe = ~v[N-1:0];
      #5;
      chk("R2 sweep", {31'd0, sout}, {31'd0, model_tree(v[N-1:0])});
      if (v % 4096 == 0) chk("R5 sweep", {16'd0, pad_oe}, 32'd0);
    end
    // Leave test mode without clock (R1)
    pad_in = 16'h0000; sfunc = 1'b1; sfunc_oe = 1'b1; core_oe = 16'h00FF;
    test_en_n = 1'b1; #1;
    chk("R1 leave", {31'd0, sout}, 32'd1);
    chk("R6 off again", {16'd0, pad_pu}, 32'd0);
    chk("R8 oe restored", {16'd0, pad_oe}, 32'h00FF);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule